// File: doc/BRIEF.md
# Parallel Host Bus Access Snooper

This block watches an asynchronous parallel host bus with chip select, command/data select, write and read strobes, a reset line and an 8- or 16-bit data bus. It never drives any of these lines. Every line is resynchronised into the fast system clock domain, and edges are found there. Each control line has its own polarity parameter. By default chip select, command select, both strobes and the reset line are active low.

When a strobe returns to its inactive level, the block captures the data word. It also records whether the access was a write or a read, and whether the command line was at its active level. A transaction window opens when chip select becomes active. When chip select goes inactive, the block emits one access record. The record holds the last capture made in the window, together with start and end timestamps from a free-running cycle counter. A pulse on the bus reset line yields a separate reset-event record, with timestamps at the assertion and release of the line.

Records leave through a valid/ready port backed by a single holding register. A record that finds the register occupied is dropped, and a sticky overflow flag is raised. A data width other than 8 or 16 is rejected at elaboration. On a 16-bit bus a parameter can exchange the two bytes of the captured word.

Top module: `hostbus_snoop`

## Requirements
- R1: After `rst_n` is released, `rec_valid` and `overflow` are both 0 and remain so while the bus is idle.
- R2: When the write strobe returns to its inactive level, the data word is captured and the access record reports `rec_dir` = 1 (write).
- R3: When the read strobe returns to its inactive level, the data word is captured and the access record reports `rec_dir` = 0 (read).
- R4: At each capture, the command line is sampled through its polarity parameter. `rec_is_cmd` = 1 when that line was at its active level (low by default), otherwise 0.
- R5: If both strobes return to their inactive levels in the same sample, the write takes priority and `rec_dir` = 1.
- R6: Chip select going inactive produces exactly one access record (`rec_kind` = 0). It carries the last capture made in the window, and `rec_t_end - rec_t_start` equals the number of clock cycles chip select was held active.
- R7: With the default byte order, `rec_value` equals the bus word. With `BYTE_SWAP` = 1 on a 16-bit bus, bits 15:8 and 7:0 of the captured word are exchanged.
- R8: Release of the bus reset line produces a reset-event record with `rec_kind` = 1, `rec_value` = 0, `rec_dir` = 0 and `rec_is_cmd` = 0. Its `rec_t_end - rec_t_start` equals the number of cycles the reset line was active.
- R9: While `rec_valid` = 1 and `rec_ready` = 0, the record and `rec_valid` hold unchanged.
- R10: A record produced while the holding register is full and not draining is dropped, and `overflow` becomes 1. `overflow` stays 1 until `rst_n` is asserted.
- R11: No record is produced while chip select stays active, however many strobes occur.
- R12: If chip select and the bus reset line both go inactive in the same sample, the access record is kept, the reset event is dropped, and `overflow` becomes 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Active-low synchronous reset of the snooper |
| bus_cs | input | 1 | Bus chip select, polarity per `CS_ACT_LOW` |
| bus_cmd | input | 1 | Command/data select, polarity per `CMD_ACT_LOW` |
| bus_wr | input | 1 | Write strobe, polarity per `WR_ACT_LOW` |
| bus_rd | input | 1 | Read strobe, polarity per `RD_ACT_LOW` |
| bus_rst | input | 1 | Bus reset line, polarity per `RST_ACT_LOW` |
| bus_data | input | DATA_W | Bus data word |
| rec_ready | input | 1 | Consumer accepts the record on offer |
| rec_valid | output | 1 | A record is on offer |
| rec_kind | output | 1 | 0 = access record, 1 = reset event |
| rec_dir | output | 1 | 1 = write, 0 = read |
| rec_is_cmd | output | 1 | 1 = command word, 0 = data word |
| rec_value | output | DATA_W | Captured word |
| rec_t_start | output | TS_W | Timestamp at window or reset start |
| rec_t_end | output | TS_W | Timestamp at window or reset end |
| overflow | output | 1 | Sticky flag for a dropped record |

## Verification
Some properties are checked on every cycle by assertions. A record on offer holds still under backpressure, the overflow flag never clears on its own, a same-sample double strobe release latches a write, and a reset-event record always carries zero value and flags. Other behaviour appears only in the directed scenarios. These are the content of each access record, the command flag, the timestamp spans, the byte order of the swapped instance, the absence of records inside a window, and the choice of which record survives a same-sample collision.

// File: rtl/hbs_pkg.sv
package hbs_pkg;

   typedef enum logic {
      KIND_ACCESS = 1'b0,
      KIND_RESET  = 1'b1
   } rec_kind_e;

   // map a raw pin level to an active-true level
   function automatic logic to_active(input logic raw, input bit act_low);
      return act_low ? ~raw : raw;
   endfunction

endpackage

// File: rtl/hbs_sync.sv
module hbs_sync #(
   parameter int W = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] meta_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         meta_q <= '0;
         q      <= '0;
      end else begin
         meta_q <= d;
         q      <= meta_q;
      end
   end
endmodule

// File: rtl/hbs_capture.sv
module hbs_capture #(
   parameter int DATA_W = 16,
   parameter int TS_W   = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_a,
   input  logic              cmd_a,
   input  logic              wr_a,
   input  logic              rd_a,
   input  logic              rst_a,
   input  logic [DATA_W-1:0] word,
   input  logic [TS_W-1:0]   ts,
   output logic              push_o,
   output logic              lost_o,
   output logic              kind_o,
   output logic              dir_o,
   output logic              cmd_o,
   output logic [DATA_W-1:0] value_o,
   output logic [TS_W-1:0]   t_start_o,
   output logic [TS_W-1:0]   t_end_o
);
   import hbs_pkg::*;

   logic              cs_p, wr_p, rd_p, rst_p;
   logic              cap_dir_q, cap_cmd_q;
   logic [DATA_W-1:0] cap_val_q;
   logic              cap_dir_n, cap_cmd_n;
   logic [DATA_W-1:0] cap_val_n;
   logic [TS_W-1:0]   t_open_q, rst_t0_q;
   logic              wr_end, rd_end;
   logic              cs_open, cs_close, rst_open, rst_close;

   assign wr_end    = wr_p & ~wr_a;
   assign rd_end    = rd_p & ~rd_a;
   assign cs_open   = ~cs_p & cs_a;
   assign cs_close  = cs_p & ~cs_a;
   assign rst_open  = ~rst_p & rst_a;
   assign rst_close = rst_p & ~rst_a;

   // capture selection: write release outranks read release
   always_comb begin
      cap_val_n = cap_val_q;
      cap_cmd_n = cap_cmd_q;
      cap_dir_n = cap_dir_q;
      if (wr_end) begin
         cap_val_n = word;
         cap_cmd_n = cmd_a;
         cap_dir_n = 1'b1;
      end else if (rd_end) begin
         cap_val_n = word;
         cap_cmd_n = cmd_a;
         cap_dir_n = 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cs_p      <= 1'b0;
         wr_p      <= 1'b0;
         rd_p      <= 1'b0;
         rst_p     <= 1'b0;
         cap_val_q <= '0;
         cap_cmd_q <= 1'b0;
         cap_dir_q <= 1'b0;
         t_open_q  <= '0;
         rst_t0_q  <= '0;
      end else begin
         cs_p      <= cs_a;
         wr_p      <= wr_a;
         rd_p      <= rd_a;
         rst_p     <= rst_a;
         cap_val_q <= cap_val_n;
         cap_cmd_q <= cap_cmd_n;
         cap_dir_q <= cap_dir_n;
         if (cs_open)  t_open_q <= ts;
         if (rst_open) rst_t0_q <= ts;
      end
   end

   // record assembly; an access close outranks a reset close
   always_comb begin
      push_o    = cs_close | rst_close;
      lost_o    = cs_close & rst_close;
      t_end_o   = ts;
      if (cs_close) begin
         kind_o    = KIND_ACCESS;
         dir_o     = cap_dir_n;
         cmd_o     = cap_cmd_n;
         value_o   = cap_val_n;
         t_start_o = t_open_q;
      end else begin
         kind_o    = KIND_RESET;
         dir_o     = 1'b0;
         cmd_o     = 1'b0;
         value_o   = '0;
         t_start_o = rst_t0_q;
      end
   end

   // R5
   wr_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_end && rd_end) |=> cap_dir_q);

endmodule

// File: rtl/hbs_outbuf.sv
module hbs_outbuf #(
   parameter int PW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   input  logic [PW-1:0] in_data,
   input  logic          lost,
   input  logic          out_ready,
   output logic          out_valid,
   output logic [PW-1:0] out_data,
   output logic          overflow
);
   logic          full_q;
   logic [PW-1:0] hold_q;
   logic          accept;

   assign accept    = in_valid & (~full_q | out_ready);
   assign out_valid = full_q;
   assign out_data  = hold_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         full_q   <= 1'b0;
         hold_q   <= '0;
         overflow <= 1'b0;
      end else begin
         if (accept) begin
            hold_q <= in_data;
            full_q <= 1'b1;
         end else if (out_ready) begin
            full_q <= 1'b0;
         end
         if ((in_valid & ~accept) | lost)
            overflow <= 1'b1;
      end
   end

   // R9
   hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

   // R10
   no_overflow_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      overflow |=> overflow);

endmodule

// File: rtl/hostbus_snoop.sv
module hostbus_snoop #(
   parameter int DATA_W      = 16,
   parameter int TS_W        = 32,
   parameter bit CS_ACT_LOW  = 1'b1,
   parameter bit CMD_ACT_LOW = 1'b1,
   parameter bit WR_ACT_LOW  = 1'b1,
   parameter bit RD_ACT_LOW  = 1'b1,
   parameter bit RST_ACT_LOW = 1'b1,
   parameter bit BYTE_SWAP   = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_cs,
   input  logic              bus_cmd,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic              bus_rst,
   input  logic [DATA_W-1:0] bus_data,
   input  logic              rec_ready,
   output logic              rec_valid,
   output logic              rec_kind,
   output logic              rec_dir,
   output logic              rec_is_cmd,
   output logic [DATA_W-1:0] rec_value,
   output logic [TS_W-1:0]   rec_t_start,
   output logic [TS_W-1:0]   rec_t_end,
   output logic              overflow
);
   import hbs_pkg::*;

   localparam int CTRL_W = 5;
   localparam int SYNC_W = CTRL_W + DATA_W;
   localparam int PAY_W  = 3 + DATA_W + 2 * TS_W;

   generate
      if (!(DATA_W == 8 || DATA_W == 16)) begin : g_bad_width
         $error("hostbus_snoop: DATA_W must be 8 or 16");
      end
      if (TS_W < 2) begin : g_bad_ts
         $error("hostbus_snoop: TS_W must be at least 2");
      end
   endgenerate

   logic [CTRL_W-1:0] ctrl_act;
   logic [SYNC_W-1:0] sync_q;
   logic [DATA_W-1:0] data_s, word;
   logic [TS_W-1:0]   ts_q;

   assign ctrl_act = {to_active(bus_cs,  CS_ACT_LOW),
                      to_active(bus_cmd, CMD_ACT_LOW),
                      to_active(bus_wr,  WR_ACT_LOW),
                      to_active(bus_rd,  RD_ACT_LOW),
                      to_active(bus_rst, RST_ACT_LOW)};

   hbs_sync #(.W(SYNC_W)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({ctrl_act, bus_data}),
      .q     (sync_q)
   );

   assign data_s = sync_q[DATA_W-1:0];

   generate
      if (DATA_W == 16 && BYTE_SWAP) begin : g_swap
         assign word = {data_s[7:0], data_s[15:8]};
      end else begin : g_nat
         assign word = data_s;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) ts_q <= '0;
      else        ts_q <= ts_q + 1'b1;
   end

   logic              c_push, c_lost, c_kind, c_dir, c_cmd;
   logic [DATA_W-1:0] c_value;
   logic [TS_W-1:0]   c_t0, c_t1;

   hbs_capture #(.DATA_W(DATA_W), .TS_W(TS_W)) u_cap (
      .clk       (clk),
      .rst_n     (rst_n),
      .cs_a      (sync_q[SYNC_W-1]),
      .cmd_a     (sync_q[SYNC_W-2]),
      .wr_a      (sync_q[SYNC_W-3]),
      .rd_a      (sync_q[SYNC_W-4]),
      .rst_a     (sync_q[SYNC_W-5]),
      .word      (word),
      .ts        (ts_q),
      .push_o    (c_push),
      .lost_o    (c_lost),
      .kind_o    (c_kind),
      .dir_o     (c_dir),
      .cmd_o     (c_cmd),
      .value_o   (c_value),
      .t_start_o (c_t0),
      .t_end_o   (c_t1)
   );

   logic [PAY_W-1:0] pay_out;

   hbs_outbuf #(.PW(PAY_W)) u_buf (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (c_push),
      .in_data   ({c_kind, c_dir, c_cmd, c_value, c_t0, c_t1}),
      .lost      (c_lost),
      .out_ready (rec_ready),
      .out_valid (rec_valid),
      .out_data  (pay_out),
      .overflow  (overflow)
   );

   assign {rec_kind, rec_dir, rec_is_cmd, rec_value, rec_t_start, rec_t_end} = pay_out;

   // R8
   reset_rec_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rec_valid && rec_kind) |-> (rec_value == '0 && !rec_is_cmd && !rec_dir));

endmodule

// File: tb/hostbus_snoop_test.sv
module hostbus_snoop_test;
   localparam int CLK_PERIOD = 10;
   localparam int DW = 16;
   localparam int TW = 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs = 1'b1, cmd = 1'b1, wr = 1'b1, rd = 1'b1, brst = 1'b1;
   logic [DW-1:0] data = '0;
   logic ready = 1'b1;

   logic le_valid, le_kind, le_dir, le_cmd, le_ovf;
   logic [DW-1:0] le_value;
   logic [TW-1:0] le_t0, le_t1;
   logic be_valid, be_kind, be_dir, be_cmd, be_ovf;
   logic [DW-1:0] be_value;
   logic [TW-1:0] be_t0, be_t1;

   int errors = 0;
   int checks = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   hostbus_snoop #(.DATA_W(DW), .TS_W(TW)) uut (
      .clk(clk), .rst_n(rst_n), .bus_cs(cs), .bus_cmd(cmd), .bus_wr(wr),
      .bus_rd(rd), .bus_rst(brst), .bus_data(data), .rec_ready(ready),
      .rec_valid(le_valid), .rec_kind(le_kind), .rec_dir(le_dir),
      .rec_is_cmd(le_cmd), .rec_value(le_value), .rec_t_start(le_t0),
      .rec_t_end(le_t1), .overflow(le_ovf));

   hostbus_snoop #(.DATA_W(DW), .TS_W(TW), .BYTE_SWAP(1'b1)) uut_be (
      .clk(clk), .rst_n(rst_n), .bus_cs(cs), .bus_cmd(cmd), .bus_wr(wr),
      .bus_rd(rd), .bus_rst(brst), .bus_data(data), .rec_ready(ready),
      .rec_valid(be_valid), .rec_kind(be_kind), .rec_dir(be_dir),
      .rec_is_cmd(be_cmd), .rec_value(be_value), .rec_t_start(be_t0),
      .rec_t_end(be_t1), .overflow(be_ovf));

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      cs = 1'b1; cmd = 1'b1; wr = 1'b1; rd = 1'b1; brst = 1'b1; ready = 1'b1;
      step(3);
      rst_n = 1'b1;
      step(2);
   endtask

   // wait for a record on the native instance; returns 0 on timeout
   task automatic wait_rec(input string req, output bit got);
      got = 1'b0;
      for (int i = 0; i < 12; i++) begin
         @(negedge clk);
         if (le_valid) begin
            got = 1'b1;
            break;
         end
      end
      if (!got) chk({req, " record timeout"}, 0, 1);
   endtask

   // one window: strobe kind 0=write 1=read 2=both, cmd_active selects command
   task automatic access(input int sk, input bit cmd_active, input logic [DW-1:0] val,
                         output int span);
      span = 0;
      cs = 1'b0;
      step(2); span += 2;
      cmd = ~cmd_active;
      data = val;
      if (sk != 1) wr = 1'b0;
      if (sk != 0) rd = 1'b0;
      step(3); span += 3;
      wr = 1'b1; rd = 1'b1;
      step(3); span += 3;
      data = 16'hDEAD;
      cmd = 1'b1;
      step(2); span += 2;
      cs = 1'b1;
   endtask

   task automatic t_reset_state();
      step(4);
      chk("R1 valid idle", le_valid, 0);
      chk("R1 overflow idle", le_ovf, 0);
   endtask

   task automatic t_write_data();
      int span; bit got;
      access(0, 1'b0, 16'h1234, span);
      wait_rec("R2", got);
      if (got) begin
         chk("R6 kind access", le_kind, 0);
         chk("R2 dir write", le_dir, 1);
         chk("R4 data flag", le_cmd, 0);
         chk("R7 little-endian value", le_value, 16'h1234);
         chk("R7 swapped value", be_value, 16'h3412);
         chk("R6 span", le_t1 - le_t0, span);
      end
      step(4);
      chk("R6 single record", le_valid, 0);
   endtask

   task automatic t_write_cmd();
      int span; bit got;
      access(0, 1'b1, 16'h00A5, span);
      wait_rec("R4", got);
      if (got) begin
         chk("R4 command flag", le_cmd, 1);
         chk("R2 dir write cmd", le_dir, 1);
         chk("R7 value cmd", le_value, 16'h00A5);
      end
      step(3);
   endtask

   task automatic t_read();
      int span; bit got;
      access(1, 1'b0, 16'hBEEF, span);
      wait_rec("R3", got);
      if (got) begin
         chk("R3 dir read", le_dir, 0);
         chk("R3 read value", le_value, 16'hBEEF);
         chk("R7 swapped read", be_value, 16'hEFBE);
         chk("R6 read span", le_t1 - le_t0, span);
      end
      step(3);
   endtask

   task automatic t_both();
      int span; bit got;
      access(2, 1'b0, 16'h5A5A, span);
      wait_rec("R5", got);
      if (got) chk("R5 write wins", le_dir, 1);
      step(3);
   endtask

   task automatic t_multi();
      bit got; int span;
      cs = 1'b0; span = 0;
      for (int k = 0; k < 3; k++) begin
         step(2); span += 2;
         data = 16'h1000 + 16'(k);
         wr = 1'b0;
         step(2); span += 2;
         wr = 1'b1;
      end
      step(4); span += 4;
      chk("R11 no record inside window", le_valid, 0);
      cs = 1'b1;
      wait_rec("R6", got);
      if (got) begin
         chk("R6 last capture kept", le_value, 16'h1002);
         chk("R6 multi span", le_t1 - le_t0, span);
      end
      step(4);
      chk("R11 one record per window", le_valid, 0);
   endtask

   task automatic t_bus_reset();
      bit got;
      brst = 1'b0;
      step(7);
      brst = 1'b1;
      wait_rec("R8", got);
      if (got) begin
         chk("R8 kind reset", le_kind, 1);
         chk("R8 zero value", le_value, 0);
         chk("R8 zero cmd", le_cmd, 0);
         chk("R8 span", le_t1 - le_t0, 7);
      end
      step(3);
   endtask

   task automatic t_collision();
      bit got;
      brst = 1'b0;
      cs = 1'b0;
      step(2);
      data = 16'h7E7E; wr = 1'b0;
      step(2);
      wr = 1'b1;
      step(2);
      cs = 1'b1; brst = 1'b1;
      wait_rec("R12", got);
      if (got) begin
         chk("R12 access kept", le_kind, 0);
         chk("R12 access value", le_value, 16'h7E7E);
      end
      step(4);
      chk("R12 reset event dropped", le_valid, 0);
      chk("R12 overflow set", le_ovf, 1);
   endtask

   task automatic t_backpressure();
      int span; bit got;
      ready = 1'b0;
      access(0, 1'b0, 16'hAAAA, span);
      wait_rec("R9", got);
      step(5);
      chk("R9 valid held", le_valid, 1);
      chk("R9 value held", le_value, 16'hAAAA);
      chk("R10 no overflow yet", le_ovf, 0);
      access(0, 1'b0, 16'hBBBB, span);
      step(6);
      chk("R10 overflow on drop", le_ovf, 1);
      chk("R10 first record kept", le_value, 16'hAAAA);
      ready = 1'b1;
      step(1);
      chk("R10 dropped record absent", le_valid, 0);
      step(5);
      chk("R10 overflow sticky", le_ovf, 1);
   endtask

   initial begin
      fork
         begin
            do_reset();
            t_reset_state();
            t_write_data();
            t_write_cmd();
            t_read();
            t_both();
            t_multi();
            t_bus_reset();
            t_collision();
            do_reset();
            chk("R1 overflow cleared by reset", le_ovf, 0);
            t_backpressure();
         end
         begin
            repeat (200000) @(posedge clk);
            chk("watchdog expired", 1, 0);
         end
      join_any
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule